// File: doc/BRIEF.md
# Incremental Long-Register Write Assembler

This block sits behind a byte-level I2C target front end. That front end turns bus activity into single-cycle events: a start, a stop, and a received byte with a flag that marks it as the address byte. The least significant bit of the address byte is the read/write bit. The block groups those events into transactions. It acknowledges the bytes meant for it and builds long registers, whose length is a whole number of four-byte words.

A long register opens with an ordinary write: subaddress, exactly four data bytes, then a stop. Later transactions to the reserved append subaddress 0xFE each add one four-byte word, in arrival order. When the last word lands, the block presents the subaddress, the assembled data and the byte count on a commit port for one clock.

Protocol errors abandon the open register and raise a one-cycle flush pulse. The errors are a new ordinary subaddress, a chunk of the wrong size, a read, and a repeated start in the middle of a chunk. An append with nothing open is dropped and flagged.

Top module: `i2c_long_reg_writer`

## Requirements
- R1: Only an address byte whose upper seven bits equal 0x1B (0x36 write, 0x37 read) is acknowledged. Any other address makes the block ignore every byte up to the next start or stop: no ack and no output.
- R2: `ack` pulses for one cycle, in the cycle after each accepted byte. Accepted bytes are a matching address byte, the subaddress byte of a write, and each data byte of a write.
- R3: A write to an ordinary subaddress s, carrying exactly four data bytes and ended by a stop, opens a register of (s mod 8)+1 words. A one-word register commits at once, with no append phase.
- R4: A write to subaddress 0xFE with exactly four data bytes and a stop appends one word to the open register. Byte k of the register, counted in arrival order from 0, appears at `commit_data[8k+7:8k]`.
- R5: When the word count reaches the register length, `commit_valid` is high for exactly one cycle, starting the cycle after the completing stop. That cycle also carries `commit_subaddr`, `commit_bytes` = 4 × length, and zero in all data bits above the register length.
- R6: A subaddress byte other than 0xFE, received while a register is open, abandons that register. `flush_pulse` then goes high for one cycle, the cycle after that byte, and the abandoned register never commits.
- R7: An append chunk with fewer or more than four data bytes, or one cut short by a repeated start, abandons the open register. `flush_pulse` goes high for one cycle after the stop or start that ends it.
- R8: A matching address byte with the read bit set (0x37), received while a register is open, abandons the register. `flush_pulse` goes high the cycle after that byte, and a later append finds no register open.
- R9: A subaddress byte 0xFE with no register open raises `append_err` for one cycle, the cycle after that byte. The following data is dropped, with no commit and no flush.
- R10: An opening write with other than four data bytes opens nothing and produces no output. A later append then raises `append_err`.
- R11: While reset is low, and after it is released, `ack`, `commit_valid`, `flush_pulse` and `append_err` are low and no register is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_start | input | 1 | Start or repeated start seen (one cycle) |
| ev_stop | input | 1 | Stop seen (one cycle) |
| ev_byte_valid | input | 1 | A received byte is on `ev_byte` (one cycle) |
| ev_is_addr | input | 1 | The byte is the address byte; bit 0 is read/write |
| ev_byte | input | 8 | Received byte |
| ack | output | 1 | Acknowledge the byte received in the previous cycle |
| commit_valid | output | 1 | Completed register on the commit port (one cycle) |
| commit_subaddr | output | 8 | Subaddress of the completed register |
| commit_data | output | 256 | Assembled data, first byte in bits 7:0 |
| commit_bytes | output | 6 | Number of valid bytes in `commit_data` |
| flush_pulse | output | 1 | An open register was abandoned (one cycle) |
| append_err | output | 1 | Append arrived with no register open (one cycle) |

## Verification
The assertions assume the front end presents at most one event per cycle and never presents a start and a stop together. They also assume a byte arrives only inside a transaction, with the address byte flagged as the first byte after a start. Under those conditions, an open is never attempted while a register is open, and commit and flush never coincide. The bench drives each start, stop and byte in a cycle of its own, followed by one idle cycle, and always sends the address byte first. The inputs therefore stay inside these assumptions even in the repeated-start and overlong-chunk cases.

// File: rtl/lrw_pkg.sv
// Package lrw_pkg
// Shared types and the subaddress-to-length lookup for the long-register
// write assembler. Assumes lengths are counted in four-byte words.
package lrw_pkg;

    // Position inside one bus transaction
    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_ADDR = 3'd1,
        PH_SUB  = 3'd2,
        PH_DATA = 3'd3,
        PH_SKIP = 3'd4
    } lrw_phase_e;

    // Length of the register at subaddress s, in words: (s mod max) + 1
    function automatic int unsigned lrw_len_words(input logic [7:0] s,
                                                  input int unsigned max_words);
        int unsigned v;
        v = int'(s);
        return (v % max_words) + 1;
    endfunction

endpackage

// File: rtl/lrw_txn_tracker.sv
// Module lrw_txn_tracker
// Follows one I2C transaction at a time from the front-end events. It
// acknowledges bytes meant for this device, captures the subaddress, stages
// up to one chunk of data bytes and counts them (saturating above a chunk).
// It reports subaddress, read and end-of-data strobes to the assembler in
// the same cycle as the event that causes them.
// Assumes at most one event per cycle and the address byte first after start.
module lrw_txn_tracker
    import lrw_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR7   = 7'h1B,
    parameter int         CHUNK_BYTES = 4,
    localparam int        CHUNK_W     = CHUNK_BYTES * 8,
    localparam int        CW          = $clog2(CHUNK_BYTES + 2)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ev_start,
    input  logic               ev_stop,
    input  logic               ev_byte_valid,
    input  logic               ev_is_addr,
    input  logic [7:0]         ev_byte,
    output logic               ack,
    output logic               sub_strobe,
    output logic [7:0]         sub_value,
    output logic               read_strobe,
    output logic               end_strobe,
    output logic               end_good,
    output logic [7:0]         end_sub,
    output logic [CHUNK_W-1:0] chunk
);

    lrw_phase_e     phase_q;
    logic [7:0]     sub_q;
    logic [CW-1:0]  cnt_q;
    logic [7:0]     byte_q [CHUNK_BYTES];
    logic           ack_q;
    logic           addr_hit;
    logic           data_byte;
    logic           accept;

    // Decode the current event against the transaction phase
    always_comb begin
        addr_hit    = ev_byte_valid && ev_is_addr && (phase_q == PH_ADDR)
                      && (ev_byte[7:1] == DEV_ADDR7);
        read_strobe = addr_hit && ev_byte[0];
        sub_strobe  = ev_byte_valid && !ev_is_addr && (phase_q == PH_SUB);
        sub_value   = ev_byte;
        data_byte   = ev_byte_valid && !ev_is_addr && (phase_q == PH_DATA);
        end_strobe  = (phase_q == PH_DATA) && (ev_stop || ev_start);
        end_good    = ev_stop && (cnt_q == CW'(CHUNK_BYTES));
        end_sub     = sub_q;
        accept      = addr_hit || sub_strobe || data_byte;
    end

    // Advance the transaction phase on start, stop and bytes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
        end else if (ev_start) begin
            phase_q <= PH_ADDR;
        end else if (ev_stop) begin
            phase_q <= PH_IDLE;
        end else if (ev_byte_valid) begin
            case (phase_q)
                PH_ADDR: phase_q <= (addr_hit && !ev_byte[0]) ? PH_SUB : PH_SKIP;
                PH_SUB:  if (!ev_is_addr) phase_q <= PH_DATA;
                default: ;
            endcase
        end
    end

    // Register the acknowledge for the byte just accepted
    always_ff @(posedge clk) begin
        if (!rst_n) ack_q <= 1'b0;
        else        ack_q <= accept;
    end

    // Hold the subaddress of the current write
    always_ff @(posedge clk) begin
        if (!rst_n)          sub_q <= 8'h00;
        else if (sub_strobe) sub_q <= ev_byte;
    end

    // Count data bytes of the current write, saturating one past a chunk
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (sub_strobe)
            cnt_q <= '0;
        else if (data_byte && (cnt_q <= CW'(CHUNK_BYTES)))
            cnt_q <= cnt_q + CW'(1);
    end

    // Stage each data byte of the chunk into its lane
    for (genvar b = 0; b < CHUNK_BYTES; b++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n)
                byte_q[b] <= 8'h00;
            else if (sub_strobe)
                byte_q[b] <= 8'h00;
            else if (data_byte && (cnt_q == CW'(b)))
                byte_q[b] <= ev_byte;
        end
        assign chunk[b*8 +: 8] = byte_q[b];
    end

    assign ack = ack_q;

    // An ack always answers a byte presented one cycle earlier
    a_r2_ack_follows_byte: assert property (@(posedge clk) disable iff (!rst_n)
        ack_q |-> $past(ev_byte_valid));

    // A transaction to a foreign address stays silent
    a_r1_foreign_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_SKIP && !ev_start) |=> !ack_q);

    // The staged byte count never runs beyond one past a chunk
    a_r7_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(CHUNK_BYTES + 1));

endmodule

// File: rtl/lrw_assembler.sv
// Module lrw_assembler
// Holds the open long register: its subaddress, target length, words held
// and the word buffer. Acts on the tracker strobes: opens on a good ordinary
// write, appends on a good append write, commits when full, and flushes on
// protocol errors. The commit port reads the buffer directly.
// Assumes the strobes it receives are mutually exclusive within a cycle.
module lrw_assembler
    import lrw_pkg::*;
#(
    parameter int         MAX_WORDS   = 8,
    parameter int         CHUNK_BYTES = 4,
    parameter logic [7:0] APPEND_SUB  = 8'hFE,
    localparam int        CHUNK_W     = CHUNK_BYTES * 8,
    localparam int        DATA_W      = MAX_WORDS * CHUNK_W,
    localparam int        WCW         = $clog2(MAX_WORDS + 1),
    localparam int        BYTE_W      = $clog2(MAX_WORDS * CHUNK_BYTES + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sub_strobe,
    input  logic [7:0]         sub_value,
    input  logic               read_strobe,
    input  logic               end_strobe,
    input  logic               end_good,
    input  logic [7:0]         end_sub,
    input  logic [CHUNK_W-1:0] chunk,
    output logic               commit_valid,
    output logic [7:0]         commit_subaddr,
    output logic [DATA_W-1:0]  commit_data,
    output logic [BYTE_W-1:0]  commit_bytes,
    output logic               flush_pulse,
    output logic               append_err
);

    logic               open_q;
    logic [7:0]         open_sub_q;
    logic [WCW-1:0]     held_q;
    logic [WCW-1:0]     target_q;
    logic [CHUNK_W-1:0] word_q [MAX_WORDS];
    logic               commit_q;
    logic               flush_q;
    logic               err_q;

    logic               do_flush;
    logic               do_err;
    logic               do_open;
    logic               do_append;
    logic               do_commit;
    logic               last_word;
    logic [WCW-1:0]     new_len;

    // Decide this cycle's action from the strobes and the open state
    always_comb begin
        new_len   = WCW'(lrw_len_words(end_sub, MAX_WORDS));
        do_flush  = open_q && (read_strobe
                    || (sub_strobe && (sub_value != APPEND_SUB))
                    || (end_strobe && (end_sub == APPEND_SUB) && !end_good));
        do_err    = sub_strobe && (sub_value == APPEND_SUB) && !open_q;
        do_append = open_q && end_strobe && end_good && (end_sub == APPEND_SUB);
        do_open   = end_strobe && end_good && (end_sub != APPEND_SUB);
        last_word = (held_q + WCW'(1)) == target_q;
        do_commit = (do_append && last_word) || (do_open && (new_len == WCW'(1)));
    end

    // Track whether a register is open and which one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q     <= 1'b0;
            open_sub_q <= 8'h00;
            target_q   <= '0;
        end else if (do_open) begin
            open_q     <= (new_len != WCW'(1));
            open_sub_q <= end_sub;
            target_q   <= new_len;
        end else if (do_append) begin
            open_q     <= !last_word;
        end else if (do_flush) begin
            open_q     <= 1'b0;
        end
    end

    // Count the words held in the buffer
    always_ff @(posedge clk) begin
        if (!rst_n)         held_q <= '0;
        else if (do_open)   held_q <= WCW'(1);
        else if (do_append) held_q <= held_q + WCW'(1);
        else if (do_flush)  held_q <= '0;
    end

    // Write, clear or drop each buffer word
    for (genvar w = 0; w < MAX_WORDS; w++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n)
                word_q[w] <= '0;
            else if (do_open)
                word_q[w] <= (w == 0) ? chunk : '0;
            else if (do_append && (held_q == WCW'(w)))
                word_q[w] <= chunk;
            else if (do_flush)
                word_q[w] <= '0;
        end
        assign commit_data[w*CHUNK_W +: CHUNK_W] = word_q[w];
    end

    // Register the single-cycle result pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            commit_q <= 1'b0;
            flush_q  <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            commit_q <= do_commit;
            flush_q  <= do_flush;
            err_q    <= do_err;
        end
    end

    assign commit_valid   = commit_q;
    assign commit_subaddr = open_sub_q;
    assign commit_bytes   = BYTE_W'(target_q) * BYTE_W'(CHUNK_BYTES);
    assign flush_pulse    = flush_q;
    assign append_err     = err_q;

    // Commit lasts exactly one cycle
    a_r5_commit_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        commit_q |=> !commit_q);

    // An open register always lacks at least one word
    a_r4_open_below_target: assert property (@(posedge clk) disable iff (!rst_n)
        open_q |-> (held_q < target_q));

    // A new opening write never lands on an open register
    a_r3_open_when_closed: assert property (@(posedge clk) disable iff (!rst_n)
        (end_strobe && end_good && end_sub != APPEND_SUB) |-> !open_q);

    // A read while open flushes and closes
    a_r8_read_flushes: assert property (@(posedge clk) disable iff (!rst_n)
        (read_strobe && open_q) |=> (flush_q && !open_q));

    // A new ordinary subaddress while open flushes
    a_r6_new_sub_flushes: assert property (@(posedge clk) disable iff (!rst_n)
        (sub_strobe && sub_value != APPEND_SUB && open_q) |=> flush_q);

    // Commit and flush never coincide
    a_r6_commit_flush_apart: assert property (@(posedge clk) disable iff (!rst_n)
        !(commit_q && flush_q));

    // The append error only reports a closed register and changes nothing
    a_r9_err_while_closed: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> (!open_q && !commit_q && !flush_q));

endmodule

// File: rtl/i2c_long_reg_writer.sv
// Module i2c_long_reg_writer
// Top of the incremental long-register write assembler. The transaction
// tracker turns front-end events into per-transaction strobes; the
// assembler builds long registers from four-byte chunks and drives the
// commit, flush and error outputs.
// Assumes one front-end event per cycle at most.
module i2c_long_reg_writer
    import lrw_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR7   = 7'h1B,
    parameter logic [7:0] APPEND_SUB  = 8'hFE,
    parameter int         MAX_WORDS   = 8,
    parameter int         CHUNK_BYTES = 4,
    localparam int        CHUNK_W     = CHUNK_BYTES * 8,
    localparam int        DATA_W      = MAX_WORDS * CHUNK_W,
    localparam int        BYTE_W      = $clog2(MAX_WORDS * CHUNK_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_start,
    input  logic              ev_stop,
    input  logic              ev_byte_valid,
    input  logic              ev_is_addr,
    input  logic [7:0]        ev_byte,
    output logic              ack,
    output logic              commit_valid,
    output logic [7:0]        commit_subaddr,
    output logic [DATA_W-1:0] commit_data,
    output logic [BYTE_W-1:0] commit_bytes,
    output logic              flush_pulse,
    output logic              append_err
);

    logic               sub_strobe;
    logic [7:0]         sub_value;
    logic               read_strobe;
    logic               end_strobe;
    logic               end_good;
    logic [7:0]         end_sub;
    logic [CHUNK_W-1:0] chunk;

    lrw_txn_tracker #(
        .DEV_ADDR7   (DEV_ADDR7),
        .CHUNK_BYTES (CHUNK_BYTES)
    ) u_tracker (
        .clk           (clk),
        .rst_n         (rst_n),
        .ev_start      (ev_start),
        .ev_stop       (ev_stop),
        .ev_byte_valid (ev_byte_valid),
        .ev_is_addr    (ev_is_addr),
        .ev_byte       (ev_byte),
        .ack           (ack),
        .sub_strobe    (sub_strobe),
        .sub_value     (sub_value),
        .read_strobe   (read_strobe),
        .end_strobe    (end_strobe),
        .end_good      (end_good),
        .end_sub       (end_sub),
        .chunk         (chunk)
    );

    lrw_assembler #(
        .MAX_WORDS   (MAX_WORDS),
        .CHUNK_BYTES (CHUNK_BYTES),
        .APPEND_SUB  (APPEND_SUB)
    ) u_assembler (
        .clk            (clk),
        .rst_n          (rst_n),
        .sub_strobe     (sub_strobe),
        .sub_value      (sub_value),
        .read_strobe    (read_strobe),
        .end_strobe     (end_strobe),
        .end_good       (end_good),
        .end_sub        (end_sub),
        .chunk          (chunk),
        .commit_valid   (commit_valid),
        .commit_subaddr (commit_subaddr),
        .commit_data    (commit_data),
        .commit_bytes   (commit_bytes),
        .flush_pulse    (flush_pulse),
        .append_err     (append_err)
    );

    // Result pulses of different kinds never share a cycle
    a_r5_single_result: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({commit_valid, flush_pulse, append_err}));

endmodule

// File: tb/test_i2c_long_reg_writer.sv
// Scoreboard bench: driver tasks push the expected results, and a monitor
// compares every result pulse the design produces against that queue.
module test_i2c_long_reg_writer;

    localparam int DW = 256;

    typedef struct packed {
        logic [1:0]    kind;   // 0 commit, 1 flush, 2 append error
        logic [7:0]    sub;
        logic [DW-1:0] data;
        logic [5:0]    nbytes;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ev_start = 1'b0;
    logic          ev_stop = 1'b0;
    logic          ev_byte_valid = 1'b0;
    logic          ev_is_addr = 1'b0;
    logic [7:0]    ev_byte = 8'h00;
    logic          ack;
    logic          commit_valid;
    logic [7:0]    commit_subaddr;
    logic [DW-1:0] commit_data;
    logic [5:0]    commit_bytes;
    logic          flush_pulse;
    logic          append_err;

    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;
    exp_t exp_q[$];
    string tag_q[$];

    always #10 clk = ~clk;

    i2c_long_reg_writer i_i2c_long_reg_writer (
        .clk            (clk),
        .rst_n          (rst_n),
        .ev_start       (ev_start),
        .ev_stop        (ev_stop),
        .ev_byte_valid  (ev_byte_valid),
        .ev_is_addr     (ev_is_addr),
        .ev_byte        (ev_byte),
        .ack            (ack),
        .commit_valid   (commit_valid),
        .commit_subaddr (commit_subaddr),
        .commit_data    (commit_data),
        .commit_bytes   (commit_bytes),
        .flush_pulse    (flush_pulse),
        .append_err     (append_err)
    );

    function automatic logic [7:0] bval(input logic [7:0] seed, input int k);
        return 8'(int'(seed) + k * 3 + 1);
    endfunction

    function automatic logic [DW-1:0] build(input logic [7:0] seed, input int nwords);
        logic [DW-1:0] d = '0;
        for (int k = 0; k < nwords * 4; k++) d[k*8 +: 8] = bval(seed, k);
        return d;
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic expect_item(input logic [1:0] kind, input logic [7:0] sub,
                               input logic [DW-1:0] data, input logic [5:0] nb,
                               input string tag);
        exp_t e;
        e.kind = kind; e.sub = sub; e.data = data; e.nbytes = nb;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic ev_begin();
        @(negedge clk); ev_start = 1'b1;
        @(negedge clk); ev_start = 1'b0;
    endtask

    task automatic ev_end();
        @(negedge clk); ev_stop = 1'b1;
        @(negedge clk); ev_stop = 1'b0;
    endtask

    task automatic put_byte(input logic [7:0] b, input bit is_addr,
                            input bit exp_ack, input string tag);
        @(negedge clk);
        ev_byte_valid = 1'b1; ev_is_addr = is_addr; ev_byte = b;
        @(negedge clk);
        ev_byte_valid = 1'b0; ev_is_addr = 1'b0;
        check(ack == exp_ack, tag, "ack", 256'(ack), 256'(exp_ack));
    endtask

    // Write transaction to this device; stop or repeated start at the end
    task automatic send_write(input logic [7:0] sub, input int first_k, input int n,
                              input logic [7:0] seed, input bit use_stop,
                              input string tag);
        ev_begin();
        put_byte(8'h36, 1'b1, 1'b1, tag);
        put_byte(sub, 1'b0, 1'b1, tag);
        for (int i = 0; i < n; i++) put_byte(bval(seed, first_k + i), 1'b0, 1'b1, tag);
        if (use_stop) ev_end();
        else begin
            ev_begin();
            ev_end();
        end
    endtask

    // Monitor: pop one expected item for each result pulse
    always @(negedge clk) begin
        if (rst_n && (commit_valid || flush_pulse || append_err)) begin
            logic [1:0] k;
            k = commit_valid ? 2'd0 : (flush_pulse ? 2'd1 : 2'd2);
            if (exp_q.size() == 0) begin
                check(1'b0, "R5", "unexpected result pulse kind", 256'(k), 256'(3));
            end else begin
                exp_t e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(k == e.kind && $countones({commit_valid, flush_pulse, append_err}) == 1,
                      t, "result kind", 256'(k), 256'(e.kind));
                if (e.kind == 2'd0) begin
                    check(commit_subaddr == e.sub, t, "commit subaddr",
                          256'(commit_subaddr), 256'(e.sub));
                    check(commit_bytes == e.nbytes, t, "commit bytes",
                          256'(commit_bytes), 256'(e.nbytes));
                    check(commit_data == e.data, t, "commit data", commit_data, e.data);
                end
            end
        end
    end

    task automatic report();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Watchdog: a hung run is a failed check
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=finished");
            report();
        end
    end

    initial begin
        // R11: reset state
        repeat (3) @(negedge clk);
        check({ack, commit_valid, flush_pulse, append_err} == 4'b0, "R11",
              "outputs in reset", 256'({ack, commit_valid, flush_pulse, append_err}), 256'(0));
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check({ack, commit_valid, flush_pulse, append_err} == 4'b0, "R11",
              "outputs after reset", 256'({ack, commit_valid, flush_pulse, append_err}), 256'(0));
        // R11: nothing open after reset, so an append is flagged
        expect_item(2'd2, 8'h00, '0, 6'd0, "R11");
        send_write(8'hFE, 0, 4, 8'h01, 1'b1, "R11");

        // R1: foreign address, nothing acknowledged, no output
        ev_begin();
        put_byte(8'h40, 1'b1, 1'b0, "R1");
        put_byte(8'h10, 1'b0, 1'b0, "R1");
        for (int i = 0; i < 4; i++) put_byte(8'hA0 + 8'(i), 1'b0, 1'b0, "R1");
        ev_end();

        // R3: one-word register commits right after its opening write
        expect_item(2'd0, 8'h10, build(8'h20, 1), 6'd4, "R3");
        send_write(8'h10, 0, 4, 8'h20, 1'b1, "R2");

        // R4: three-word register filled by two appends, arrival order kept
        send_write(8'h22, 0, 4, 8'h40, 1'b1, "R4");
        send_write(8'hFE, 4, 4, 8'h40, 1'b1, "R4");
        expect_item(2'd0, 8'h22, build(8'h40, 3), 6'd12, "R4");
        send_write(8'hFE, 8, 4, 8'h40, 1'b1, "R4");

        // R9: append with nothing open is flagged and dropped
        expect_item(2'd2, 8'h00, '0, 6'd0, "R9");
        send_write(8'hFE, 0, 4, 8'h55, 1'b1, "R9");

        // R6: new ordinary subaddress abandons the open register
        send_write(8'h21, 0, 4, 8'h60, 1'b1, "R6");
        expect_item(2'd1, 8'h00, '0, 6'd0, "R6");
        send_write(8'h05, 0, 4, 8'h70, 1'b1, "R6");

        // R8: read while open flushes; later append finds nothing open
        expect_item(2'd1, 8'h00, '0, 6'd0, "R8");
        ev_begin();
        put_byte(8'h37, 1'b1, 1'b1, "R8");
        ev_end();
        expect_item(2'd2, 8'h00, '0, 6'd0, "R8");
        send_write(8'hFE, 0, 4, 8'h71, 1'b1, "R8");

        // R7: short append, long append, append cut by repeated start
        send_write(8'h23, 0, 4, 8'h80, 1'b1, "R7");
        expect_item(2'd1, 8'h00, '0, 6'd0, "R7");
        send_write(8'hFE, 4, 3, 8'h80, 1'b1, "R7");
        send_write(8'h23, 0, 4, 8'h81, 1'b1, "R7");
        expect_item(2'd1, 8'h00, '0, 6'd0, "R7");
        send_write(8'hFE, 4, 5, 8'h81, 1'b1, "R7");
        send_write(8'h23, 0, 4, 8'h82, 1'b1, "R7");
        expect_item(2'd1, 8'h00, '0, 6'd0, "R7");
        send_write(8'hFE, 4, 2, 8'h82, 1'b0, "R7");

        // R10: opening writes of wrong size open nothing
        send_write(8'h21, 0, 5, 8'h90, 1'b1, "R10");
        expect_item(2'd2, 8'h00, '0, 6'd0, "R10");
        send_write(8'hFE, 4, 4, 8'h90, 1'b1, "R10");
        send_write(8'h21, 0, 3, 8'h91, 1'b1, "R10");
        expect_item(2'd2, 8'h00, '0, 6'd0, "R10");
        send_write(8'hFE, 4, 4, 8'h91, 1'b1, "R10");

        // R5: full eight-word register, all 256 bits, 32 bytes
        send_write(8'h07, 0, 4, 8'hC0, 1'b1, "R5");
        for (int j = 1; j < 7; j++) send_write(8'hFE, j * 4, 4, 8'hC0, 1'b1, "R5");
        expect_item(2'd0, 8'h07, build(8'hC0, 8), 6'd32, "R5");
        send_write(8'hFE, 28, 4, 8'hC0, 1'b1, "R5");

        // R5: a two-word register leaves upper data bits zero
        send_write(8'h29, 0, 4, 8'hD0, 1'b1, "R5");
        expect_item(2'd0, 8'h29, build(8'hD0, 2), 6'd8, "R5");
        send_write(8'hFE, 4, 4, 8'hD0, 1'b1, "R5");

        repeat (5) @(negedge clk);
        check(exp_q.size() == 0, "R5", "expected results left over",
              256'(exp_q.size()), 256'(0));
        done = 1'b1;
        report();
    end

endmodule